// File: doc/BRIEF.md
# NAND Sector Hamming Code Engine

This block computes a single-error-correcting Hamming code over one flash sector while the sector's bytes stream past it, one byte per accepted cycle. Each data bit has a 12-bit bit address, formed as byte offset times eight plus the bit position inside the byte. For every address line the block keeps two running parities: one over the bits whose address has that line set, and one over the bits whose address has it clear. The two sets are packed into a 24-bit code. The code is inverted, so that an erased sector (all bytes 0xFF) produces a code of all ones.

On read-back the host presents the code that was stored in flash. The block XORs it with the freshly computed code and gives a verdict. The verdict is one of four: clean; a single data bit flipped, with its byte offset and bit index; a single bit flipped inside the stored code only, with the data still good; or uncorrectable. The block only reports where a flip is. Patching the buffer is left to the host. A start pulse clears the accumulated parity, and so does a take pulse once the result has been consumed.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, and in the cycle after a `start` pulse, `done` is 0 and `code` is 0xFFFFFF.
- R2: `done` rises in the cycle after the 512th byte is accepted. Bytes offered while `done` is 1 are ignored, and `code` stays unchanged.
- R3: `code[23:12]` bit j is the inverted XOR of all data bits whose 12-bit address (offset*8 + bit position) has bit j set. `code[11:0]` bit j is the inverted XOR of the bits whose address has bit j clear. `code[7:0]` is the byte stored first in flash.
- R4: A sector of 512 bytes of 0xFF yields `code` = 0xFFFFFF.
- R5: With `done` high, `verdict` is 0 (clean) when `storedCode` equals `code`.
- R6: `verdict` is 1 (data fix) when syndrome = `storedCode ^ code` has `syn[23:12] ^ syn[11:0]` = 0xFFF and `syn[23:15]` is below the sector size. In that case `errByte` = `syn[23:15]` and `errBit` = `syn[14:12]`.
- R7: `verdict` is 2 (code hit) when the syndrome has exactly one bit set.
- R8: `verdict` is 3 (uncorrectable) for every other nonzero syndrome, for example two flipped data bits.
- R9: A `take` pulse while `done` is 1 clears `done`, and `code` returns to 0xFFFFFF in the next cycle.
- R10: Cycles with `inValid` low accept nothing, so idle gaps between bytes leave the result unchanged.
- R11: `errByte` and `errBit` are 0 whenever `verdict` is not 1.
- R12: A byte offered in the same cycle as `start` is dropped. Counting begins with the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears parity and byte count |
| take | input | 1 | Consumes the result; clears it when `done` |
| inValid | input | 1 | `inByte` carries a sector byte this cycle |
| inByte | input | 8 | Sector data byte, in offset order |
| storedCode | input | 24 | Code read back from flash |
| done | output | 1 | Full sector accumulated; result valid |
| code | output | 24 | Inverted packed Hamming code |
| verdict | output | 2 | 0 clean, 1 data fix, 2 code hit, 3 uncorrectable |
| errByte | output | 9 | Byte offset of the flipped data bit |
| errBit | output | 3 | Bit index of the flipped data bit |

## Verification
A wrong internal byte count shows up at the ports as `done` rising one or more cycles early or late. It also corrupts the address-line parities, and that corruption becomes visible in `code` as soon as `done` is high. A parity register that is left uncleared or updated with the wrong weight appears as a mismatch against an independently computed code for every pattern the bench uses. A misclassification shows in `verdict`, `errByte` and `errBit` in the same cycle that `storedCode` is applied, because those outputs are combinational over the finished code.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int BIT_IDX_W = 3;
  localparam int OFFSET_W  = 9;
  localparam int HALF_W    = BIT_IDX_W + OFFSET_W;
  localparam int CODE_W    = 2 * HALF_W;

  typedef enum logic [1:0] {
    VERD_CLEAN    = 2'd0,
    VERD_DATA_FIX = 2'd1,
    VERD_CODE_HIT = 2'd2,
    VERD_UNCORR   = 2'd3
  } verdict_e;

  typedef struct packed {
    logic                clear;
    logic                accept;
    logic [OFFSET_W-1:0] offset;
  } ecc_strobe_t;
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        take,
  input  logic        inValid,
  output ecc_strobe_t strobe,
  output logic        done
);
  localparam logic [OFFSET_W-1:0] LAST_OFFSET = OFFSET_W'(SECTOR_BYTES - 1);

  logic [OFFSET_W-1:0] offset;

  assign strobe.clear  = start | (take & done);
  assign strobe.accept = inValid & ~done & ~strobe.clear;
  assign strobe.offset = offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset <= '0;
      done   <= 1'b0;
    end else if (strobe.clear) begin
      offset <= '0;
      done   <= 1'b0;
    end else if (strobe.accept) begin
      if (offset == LAST_OFFSET) done <= 1'b1;
      else                       offset <= offset + 1'b1;
    end
  end

  // R1 / R9: a clear leaves the counter idle and the result withdrawn
  p_clear_resets_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!done && offset == '0));

  // R2: completion only follows an accepted byte
  p_done_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strobe.accept));

  // R2: a finished sector holds until cleared
  p_hold_when_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !strobe.clear) |=> (done && $stable(offset)));
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ecc_strobe_t       strobe,
  input  logic [7:0]        inByte,
  output logic [CODE_W-1:0] codeOut
);
  logic [HALF_W-1:0] oddPar, evenPar;
  logic [HALF_W-1:0] oddStep, evenStep;
  logic              rowPar;

  assign rowPar = ^inByte;

  // bit-index lines: parity of the byte's bits split by position
  genvar j;
  generate
    for (j = 0; j < BIT_IDX_W; j++) begin : g_col
      always_comb begin
        oddStep[j]  = 1'b0;
        evenStep[j] = 1'b0;
        for (int i = 0; i < 8; i++) begin
          if (((i >> j) & 1) == 1) oddStep[j]  = oddStep[j]  ^ inByte[i];
          else                     evenStep[j] = evenStep[j] ^ inByte[i];
        end
      end
    end
    // byte-address lines: whole-byte parity steered by the offset bit
    for (j = BIT_IDX_W; j < HALF_W; j++) begin : g_row
      assign oddStep[j]  = rowPar &  strobe.offset[j-BIT_IDX_W];
      assign evenStep[j] = rowPar & ~strobe.offset[j-BIT_IDX_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oddPar  <= '0;
      evenPar <= '0;
    end else if (strobe.clear) begin
      oddPar  <= '0;
      evenPar <= '0;
    end else if (strobe.accept) begin
      oddPar  <= oddPar  ^ oddStep;
      evenPar <= evenPar ^ evenStep;
    end
  end

  assign codeOut = ~{oddPar, evenPar};

  // R1: a clear returns the code to the erased value
  p_clear_erased_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (codeOut == {CODE_W{1'b1}}));

  // R10: no accepted byte, no change
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !strobe.clear) |=> $stable(codeOut));
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CODE_W-1:0]    codeIn,
  input  logic [CODE_W-1:0]    storedCode,
  output verdict_e             verdict,
  output logic [OFFSET_W-1:0]  errByte,
  output logic [BIT_IDX_W-1:0] errBit
);
  logic [CODE_W-1:0]   syn;
  logic [OFFSET_W-1:0] synByte;
  logic                halvesFlip;

  assign syn        = storedCode ^ codeIn;
  assign synByte    = syn[CODE_W-1 -: OFFSET_W];
  assign halvesFlip = ((syn[CODE_W-1:HALF_W] ^ syn[HALF_W-1:0]) == {HALF_W{1'b1}});

  always_comb begin
    verdict = VERD_UNCORR;
    errByte = '0;
    errBit  = '0;
    if (syn == '0) begin
      verdict = VERD_CLEAN;
    end else if (halvesFlip && (32'(synByte) < SECTOR_BYTES)) begin
      verdict = VERD_DATA_FIX;
      errByte = synByte;
      errBit  = syn[HALF_W +: BIT_IDX_W];
    end else if ($onehot(syn)) begin
      verdict = VERD_CODE_HIT;
    end
  end

  // R5: a clean verdict means the two codes agree
  p_clean_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == VERD_CLEAN) |-> (storedCode == codeIn));

  // R7: a code hit differs from the stored code in one bit
  p_code_hit_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == VERD_CODE_HIT) |-> ($countones(storedCode ^ codeIn) == 1));

  // R11: the location is zero outside a data fix
  p_loc_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (verdict != VERD_DATA_FIX) |-> (errByte == '0 && errBit == '0));
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 take,
  input  logic                 inValid,
  input  logic [7:0]           inByte,
  input  logic [CODE_W-1:0]    storedCode,
  output logic                 done,
  output logic [CODE_W-1:0]    code,
  output logic [1:0]           verdict,
  output logic [OFFSET_W-1:0]  errByte,
  output logic [BIT_IDX_W-1:0] errBit
);
  ecc_strobe_t strobe;
  verdict_e    verdictE;

  ecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .take(take),
    .inValid(inValid), .strobe(strobe), .done(done)
  );

  ecc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte), .codeOut(code)
  );

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .clk(clk), .rstN(rstN), .codeIn(code), .storedCode(storedCode),
    .verdict(verdictE), .errByte(errByte), .errBit(errBit)
  );

  assign verdict = verdictE;
endmodule

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;
  typedef struct packed {
    logic [7:0] mult;
    logic [7:0] add;
    logic [1:0] kind;   // 0 clean, 1 data flip, 2 code flip, 3 double flip
    logic [9:0] p1;
    logic [9:0] p2;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,  8'hFF, 2'd0, 10'd0,   10'd0},
    '{8'd7,  8'd3,  2'd0, 10'd0,   10'd0},
    '{8'd13, 8'd5,  2'd1, 10'd300, 10'd5},
    '{8'd1,  8'd0,  2'd1, 10'd511, 10'd7},
    '{8'd29, 8'd11, 2'd1, 10'd0,   10'd0},
    '{8'd3,  8'd1,  2'd2, 10'd0,   10'd0},
    '{8'd3,  8'd1,  2'd2, 10'd23,  10'd0},
    '{8'd5,  8'd9,  2'd3, 10'd10,  10'd400},
    '{8'd5,  8'd9,  2'd2, 10'd12,  10'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, take = 1'b0, inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic [23:0] storedCode = '0;
  logic        done;
  logic [23:0] code;
  logic [1:0]  verdict;
  logic [8:0]  errByte;
  logic [2:0]  errBit;

  int total = 0, failed = 0;

  always #5 clk = ~clk;

  nand_hamming_ecc u_dut (
    .clk(clk), .rstN(rstN), .start(start), .take(take), .inValid(inValid),
    .inByte(inByte), .storedCode(storedCode), .done(done), .code(code),
    .verdict(verdict), .errByte(errByte), .errBit(errBit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: walk every set bit and toggle the parities of its address lines
  task automatic refAdd(input int off, input logic [7:0] b,
                        inout logic [11:0] oddP, inout logic [11:0] evenP);
    for (int i = 0; i < 8; i++) begin
      if (b[i]) begin
        logic [11:0] addr;
        addr = 12'(off * 8 + i);
        for (int k = 0; k < 12; k++) begin
          if (addr[k]) oddP[k]  = ~oddP[k];
          else         evenP[k] = ~evenP[k];
        end
      end
    end
  endtask

  // start pulse then 512 bytes; returns the reference code
  task automatic runSector(input logic [7:0] mult, input logic [7:0] add,
                           input int fA, input int bA, input int fB, input int bB,
                           input bit gaps, output logic [23:0] refCode);
    logic [11:0] oddP, evenP;
    oddP = '0; evenP = '0;
    @(negedge clk); start = 1'b1; inValid = 1'b0;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < 512; n++) begin
      logic [7:0] b;
      b = 8'(n * mult + add);
      if (n == fA) b[bA] = ~b[bA];
      if (n == fB) b[bB] = ~b[bB];
      if (gaps && (n % 5 == 4)) begin
        inValid = 1'b0; inByte = ~b;
        @(negedge clk);
      end
      inValid = 1'b1; inByte = b;
      refAdd(n, b, oddP, evenP);
      @(negedge clk);
    end
    inValid = 1'b0;
    refCode = ~{oddP, evenP};
  endtask

  initial begin
    #(200000 * 10);
    failed++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    logic [23:0] cleanRef, flipRef, cleanCode;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset code", {8'd0, code}, 32'hFFFFFF);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      t = VECS[v];
      runSector(t.mult, t.add, 1023, 0, 1023, 0, 1'b0, cleanRef);
      chk("R2 done after last byte", {31'd0, done}, 32'd1);
      chk("R3 code matches model", {8'd0, code}, {8'd0, cleanRef});
      if (t.mult == 0 && t.add == 8'hFF)
        chk("R4 erased code", {8'd0, code}, 32'hFFFFFF);
      cleanCode = code;
      case (t.kind)
        2'd0: begin
          storedCode = cleanCode; #1;
          chk("R5 clean verdict", {30'd0, verdict}, 32'd0);
          chk("R11 loc zero", {20'd0, errByte, errBit}, 32'd0);
        end
        2'd1: begin
          storedCode = cleanCode;
          runSector(t.mult, t.add, int'(t.p1), int'(t.p2), 1023, 0, 1'b0, flipRef);
          chk("R3 flipped code", {8'd0, code}, {8'd0, flipRef});
          chk("R6 data fix verdict", {30'd0, verdict}, 32'd1);
          chk("R6 err byte", {23'd0, errByte}, {22'd0, t.p1});
          chk("R6 err bit", {29'd0, errBit}, {22'd0, t.p2});
        end
        2'd2: begin
          storedCode = cleanCode ^ (24'd1 << t.p1); #1;
          chk("R7 code hit verdict", {30'd0, verdict}, 32'd2);
          chk("R11 loc zero", {20'd0, errByte, errBit}, 32'd0);
        end
        default: begin
          storedCode = cleanCode;
          runSector(t.mult, t.add, int'(t.p1), 0, int'(t.p2), 7, 1'b0, flipRef);
          chk("R8 uncorrectable verdict", {30'd0, verdict}, 32'd3);
          chk("R11 loc zero", {20'd0, errByte, errBit}, 32'd0);
        end
      endcase
    end

    // R2: extra bytes after completion are ignored
    runSector(8'd9, 8'd2, 1023, 0, 1023, 0, 1'b0, cleanRef);
    for (int n = 0; n < 6; n++) begin
      inValid = 1'b1; inByte = 8'(8'hA5 + n);
      @(negedge clk);
    end
    inValid = 1'b0;
    chk("R2 extra bytes ignored", {8'd0, code}, {8'd0, cleanRef});
    chk("R2 still done", {31'd0, done}, 32'd1);

    // R10: idle gaps inside the stream
    runSector(8'd9, 8'd2, 1023, 0, 1023, 0, 1'b1, flipRef);
    chk("R10 gaps same code", {8'd0, code}, {8'd0, cleanRef});

    // R9: take clears the finished result
    take = 1'b1;
    @(negedge clk); take = 1'b0;
    chk("R9 take clears done", {31'd0, done}, 32'd0);
    chk("R9 take clears code", {8'd0, code}, 32'hFFFFFF);

    // R1: start mid-stream restarts counting
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 start clears done", {31'd0, done}, 32'd0);
    chk("R1 start clears code", {8'd0, code}, 32'hFFFFFF);

    // R12: byte alongside start is dropped
    begin
      logic [11:0] oddP, evenP;
      oddP = '0; evenP = '0;
      @(negedge clk); start = 1'b1; inValid = 1'b1; inByte = 8'h5A;
      @(negedge clk); start = 1'b0;
      for (int n = 0; n < 512; n++) begin
        logic [7:0] b;
        b = 8'(n * 11 + 6);
        inByte = b;
        refAdd(n, b, oddP, evenP);
        if (n == 511) chk("R12 not done before last byte", {31'd0, done}, 32'd0);
        @(negedge clk);
      end
      inValid = 1'b0;
      chk("R12 done after 512 counted", {31'd0, done}, 32'd1);
      chk("R12 code excludes start byte", {8'd0, code}, {8'd0, ~{oddP, evenP}});
    end

    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule